// File: doc/BRIEF.md
# Multichannel Zero-Crossing Detector with Timeout

This block watches six signed sample streams: the three phase voltages and the three phase currents of a polyphase metering front end. Each stream is a low-pass filtered waveform that arrives with its own sample-valid strobe. On every stream the block reports each zero crossing as a sticky status bit. A 16-bit down-counting watchdog on each stream raises a second sticky bit when no crossing arrives within a programmable number of 16 kHz ticks.

Voltage streams carry an amplitude gate, so a waveform whose half-cycle peak stays below one tenth of full scale produces no crossings. Current streams report crossings at any amplitude. A mask register selects which status bits pull the active-low interrupt line. Software clears status bits by writing ones to them.

Lane order inside `sampleData` and `sampleValid` is lane 0 = voltage A, 1 = voltage B, 2 = voltage C, 3 = current A, 4 = current B, 5 = current C. Lane k occupies `sampleData[k*SAMPLE_W +: SAMPLE_W]`.

Top module: `zc_watch`

## Requirements
- R1: A crossing candidate on a lane is a valid sample whose sign bit (the MSB; zero counts as positive) differs from the sign bit of that lane's previous valid sample. The first valid sample after reset never forms a candidate.
- R2: A counted crossing on lane k sets status bit 9+k (bits 9..11 for voltage A..C, bits 12..14 for current A..C), visible after the clock edge that samples the valid strobe.
- R3: On a voltage lane a candidate counts only if the largest absolute sample value since the previous sign change, including the last sample before the change, is at least GATE_LEVEL = (2^(SAMPLE_W-1)-1)/FS_DIV. The default is 838860 for SAMPLE_W=24 and FS_DIV=10.
- R4: On a current lane every candidate counts, whatever its amplitude.
- R5: Every lane counter resets to 0xFFFF. A write of the timeout value reloads all six counters with the written value. A counted crossing reloads that lane's counter with the current timeout value. Each tickEn pulse decrements a non-zero counter by one.
- R6: A lane's timeout status bit 3+k (bits 3..5 voltage A..C, bits 6..8 current A..C) is set by the tick that takes its counter from 1 to 0, exactly N ticks after a load with value N. The counter then holds at zero and does not set the bit again until it is reloaded. A value of zero never times out.
- R7: Status bits are sticky. Writing a 1 to a status bit through the clear port clears it. When a hardware set and a clear reach the same bit in the same cycle, the set wins.
- R8: irqN is low exactly when some status bit and its mask bit are both 1. maskOut returns the last written mask.
- R9: After reset, status and mask are zero and irqN is high. Status bits other than 3..14 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleData | input | 6*SAMPLE_W | Six signed samples, lane k at bits k*SAMPLE_W and up |
| sampleValid | input | 6 | Per-lane sample strobe |
| tickEn | input | 1 | 16 kHz timeout tick enable, one cycle wide |
| toutWrEn | input | 1 | Write strobe for the shared timeout value |
| toutWrData | input | 16 | New timeout value |
| maskWrEn | input | 1 | Write strobe for the mask register |
| maskWrData | input | 32 | New mask value |
| clrWrEn | input | 1 | Write strobe for the write-one-to-clear status port |
| clrWrData | input | 32 | Ones mark status bits to clear |
| statusOut | output | 32 | Sticky status register |
| maskOut | output | 32 | Mask register |
| irqN | output | 1 | Active-low interrupt |

## Verification
The assertions check the following on every cycle: status bits stay set until a clear names them, the interrupt level tracks the masked status, reserved status bits stay at zero, a timeout bit rises only after a tick, and a crossing bit rises only after a valid sample. The choice of which sign changes count cannot be seen by a property: gating against the half-cycle peak (including both sides of the threshold boundary), the absence of any gate on current lanes, and the first-sample rule are shown only by the vector table. The exact tick count to a timeout, the hold at zero, the per-lane reload on a crossing and the set-over-clear priority are shown by directed scenarios.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int NUM_CH  = 6;
  localparam int NUM_V   = 3;
  localparam int TOUT_W  = 16;
  localparam int STAT_W  = 32;
  localparam int ZC_BASE = 9;
  localparam int TO_BASE = 3;
  localparam logic [TOUT_W-1:0] TOUT_RST = '1;

  // events raised by the lanes toward the status logic
  typedef struct packed {
    logic [NUM_CH-1:0] zcHit;
    logic [NUM_CH-1:0] toHit;
  } laneEvt_t;

  // commands from the control toward the lanes
  typedef struct packed {
    logic              reloadAll;
    logic [TOUT_W-1:0] reloadVal;
  } ctlCmd_t;
endpackage

// File: rtl/zc_lane.sv
module zc_lane
  import zc_pkg::*;
#(
  parameter int                  SAMPLE_W   = 24,
  parameter bit                  GATED      = 1'b1,
  parameter logic [SAMPLE_W-1:0] GATE_LEVEL = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                valid,
  input  logic                tick,
  input  ctlCmd_t             cmd,
  output logic                zcHit,
  output logic                toHit
);
  logic              havePrev;
  logic              prevSign;
  logic [TOUT_W-1:0] cnt;
  logic              curSign;
  logic              signFlip;
  logic              qualified;

  assign curSign  = sample[SAMPLE_W-1];
  assign signFlip = valid && havePrev && (curSign != prevSign);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePrev <= 1'b0;
      prevSign <= 1'b0;
    end else if (valid) begin
      havePrev <= 1'b1;
      prevSign <= curSign;
    end
  end

  generate
    if (GATED) begin : g_gate
      logic [SAMPLE_W-1:0] peak;
      logic [SAMPLE_W-1:0] absVal;
      assign absVal    = curSign ? (~sample + 1'b1) : sample;
      assign qualified = (peak >= GATE_LEVEL);
      always_ff @(posedge clk) begin
        if (!rstN) begin
          peak <= '0;
        end else if (valid) begin
          if (signFlip)            peak <= absVal;
          else if (absVal > peak)  peak <= absVal;
        end
      end
    end else begin : g_nogate
      assign qualified = 1'b1;
    end
  endgenerate

  assign zcHit = signFlip && qualified;
  assign toHit = tick && (cnt == TOUT_W'(1)) && !zcHit && !cmd.reloadAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= TOUT_RST;
    end else if (cmd.reloadAll || zcHit) begin
      cnt <= cmd.reloadVal;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/zc_datapath.sv
module zc_datapath
  import zc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int FS_DIV   = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  input  logic [NUM_CH-1:0]          sampleValid,
  input  logic                       tickEn,
  input  ctlCmd_t                    cmd,
  output laneEvt_t                   evt
);
  localparam logic [SAMPLE_W-1:0] FULL_SCALE = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] GATE_LEVEL = FULL_SCALE / SAMPLE_W'(FS_DIV);

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
      zc_lane #(
        .SAMPLE_W  (SAMPLE_W),
        .GATED     (k < NUM_V),
        .GATE_LEVEL(GATE_LEVEL)
      ) u_lane (
        .clk   (clk),
        .rstN  (rstN),
        .sample(sampleData[k*SAMPLE_W +: SAMPLE_W]),
        .valid (sampleValid[k]),
        .tick  (tickEn),
        .cmd   (cmd),
        .zcHit (evt.zcHit[k]),
        .toHit (evt.toHit[k])
      );
    end
  endgenerate
endmodule

// File: rtl/zc_control.sv
module zc_control
  import zc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              toutWrEn,
  input  logic [TOUT_W-1:0] toutWrData,
  input  logic              maskWrEn,
  input  logic [STAT_W-1:0] maskWrData,
  input  logic              clrWrEn,
  input  logic [STAT_W-1:0] clrWrData,
  input  laneEvt_t          evt,
  output ctlCmd_t           cmd,
  output logic [STAT_W-1:0] statusOut,
  output logic [STAT_W-1:0] maskOut,
  output logic              irqN
);
  logic [TOUT_W-1:0] toutReg;
  logic [STAT_W-1:0] statusReg;
  logic [STAT_W-1:0] maskReg;
  logic [STAT_W-1:0] hwSet;
  logic [STAT_W-1:0] clrMask;

  assign cmd.reloadAll = toutWrEn;
  assign cmd.reloadVal = toutWrEn ? toutWrData : toutReg;

  always_comb begin
    hwSet = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      hwSet[ZC_BASE+k] = evt.zcHit[k];
      hwSet[TO_BASE+k] = evt.toHit[k];
    end
  end

  assign clrMask = clrWrEn ? clrWrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toutReg   <= TOUT_RST;
      statusReg <= '0;
      maskReg   <= '0;
    end else begin
      if (toutWrEn) toutReg <= toutWrData;
      if (maskWrEn) maskReg <= maskWrData;
      statusReg <= (statusReg & ~clrMask) | hwSet;
    end
  end

  assign statusOut = statusReg;
  assign maskOut   = maskReg;
  assign irqN      = ~|(statusReg & maskReg);
endmodule

// File: rtl/zc_watch.sv
module zc_watch
  import zc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int FS_DIV   = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [6*SAMPLE_W-1:0]      sampleData,
  input  logic [5:0]                 sampleValid,
  input  logic                       tickEn,
  input  logic                       toutWrEn,
  input  logic [15:0]                toutWrData,
  input  logic                       maskWrEn,
  input  logic [31:0]                maskWrData,
  input  logic                       clrWrEn,
  input  logic [31:0]                clrWrData,
  output logic [31:0]                statusOut,
  output logic [31:0]                maskOut,
  output logic                       irqN
);
  laneEvt_t evt;
  ctlCmd_t  cmd;

  zc_datapath #(.SAMPLE_W(SAMPLE_W), .FS_DIV(FS_DIV)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleData (sampleData),
    .sampleValid(sampleValid),
    .tickEn     (tickEn),
    .cmd        (cmd),
    .evt        (evt)
  );

  zc_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .toutWrEn  (toutWrEn),
    .toutWrData(toutWrData),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .clrWrEn   (clrWrEn),
    .clrWrData (clrWrData),
    .evt       (evt),
    .cmd       (cmd),
    .statusOut (statusOut),
    .maskOut   (maskOut),
    .irqN      (irqN)
  );
endmodule

// File: rtl/zc_watch_chk.sv
module zc_watch_chk (
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  sampleValid,
  input logic        tickEn,
  input logic        clrWrEn,
  input logic [31:0] clrWrData,
  input logic [31:0] statusOut,
  input logic [31:0] maskOut,
  input logic        irqN
);
  logic [31:0] clrSeen;
  assign clrSeen = clrWrEn ? clrWrData : 32'h0;

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusOut) & ~$past(clrSeen)) & ~statusOut) == 32'h0));

  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusOut & maskOut)) |-> !irqN);

  // R8
  irq_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusOut & maskOut)) |-> irqN);

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut & ~32'h0000_7FF8) == 32'h0);

  // R6
  timeout_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusOut[8:3] & ~$past(statusOut[8:3])) != 6'h0) |-> $past(tickEn));

  // R2
  zc_after_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusOut[14:9] & ~$past(statusOut[14:9]) & ~$past(sampleValid)) == 6'h0));
endmodule

bind zc_watch zc_watch_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .tickEn     (tickEn),
  .clrWrEn    (clrWrEn),
  .clrWrData  (clrWrData),
  .statusOut  (statusOut),
  .maskOut    (maskOut),
  .irqN       (irqN)
);

// File: tb/tb_zc_watch.sv
module tb_zc_watch;
  localparam int W = 24;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [6*W-1:0]  sampleData = '0;
  logic [5:0]      sampleValid = '0;
  logic            tickEn = 1'b0;
  logic            toutWrEn = 1'b0;
  logic [15:0]     toutWrData = '0;
  logic            maskWrEn = 1'b0;
  logic [31:0]     maskWrData = '0;
  logic            clrWrEn = 1'b0;
  logic [31:0]     clrWrData = '0;
  logic [31:0]     statusOut;
  logic [31:0]     maskOut;
  logic            irqN;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zc_watch #(.SAMPLE_W(W), .FS_DIV(10)) dut (.*);

  typedef struct packed {
    logic [2:0]          ch;
    logic signed [W-1:0] smp;
    logic                exp;
  } vec_t;

  // gate level for voltage lanes: (2^23-1)/10 = 838860
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0,  24'sd2000000, 1'b0},  // R1 first sample
    '{3'd0, -24'sd2000000, 1'b1},  // R3 peak 2000000
    '{3'd0,  24'sd100000,  1'b1},  // R3 negative half peak 2000000
    '{3'd0, -24'sd100000,  1'b0},  // R3 peak 100000 below gate
    '{3'd0, -24'sd900000,  1'b0},  // R1 same sign
    '{3'd0,  24'sd5,       1'b1},  // R3 peak 900000
    '{3'd3,  24'sd10,      1'b0},  // R1 first sample
    '{3'd3, -24'sd10,      1'b1},  // R4 tiny amplitude
    '{3'd3,  24'sd0,       1'b1},  // R1 zero is positive
    '{3'd1, -24'sd3000000, 1'b0},
    '{3'd1,  24'sd838860,  1'b1},
    '{3'd1, -24'sd838860,  1'b1},  // R3 peak exactly at gate
    '{3'd1, -24'sd1,       1'b0},
    '{3'd2,  24'sd838859,  1'b0},
    '{3'd2, -24'sd838859,  1'b0},  // R3 one below gate
    '{3'd5,  24'sd1,       1'b0},
    '{3'd5, -24'sd1,       1'b1}   // R4 current lane C
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearAll(input logic [31:0] bits);
    @(negedge clk); clrWrEn = 1'b1; clrWrData = bits;
    @(negedge clk); clrWrEn = 1'b0; clrWrData = '0;
  endtask

  task automatic sendSample(input int ch, input logic [W-1:0] smp, input bit withClr,
                            input logic [31:0] clrBits);
    @(negedge clk);
    sampleData[ch*W +: W] = smp;
    sampleValid = 6'(1 << ch);
    if (withClr) begin clrWrEn = 1'b1; clrWrData = clrBits; end
    @(negedge clk);
    sampleValid = '0;
    clrWrEn = 1'b0; clrWrData = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic writeTout(input logic [15:0] v);
    @(negedge clk); toutWrEn = 1'b1; toutWrData = v;
    @(negedge clk); toutWrEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 status reset", statusOut, 32'h0);
    chk("R9 mask reset", maskOut, 32'h0);
    chk("R9 irq reset", {31'h0, irqN}, 32'h1);

    // R1 R2 R3 R4 vector table
    for (int v = 0; v < NV; v++) begin
      clearAll(32'hFFFF_FFFF);
      sendSample(int'(VECS[v].ch), VECS[v].smp, 1'b0, '0);
      chk($sformatf("R1/R2/R3/R4 vector %0d", v), statusOut,
          VECS[v].exp ? (32'h1 << (9 + int'(VECS[v].ch))) : 32'h0);
    end

    // R6 exact tick count
    clearAll(32'hFFFF_FFFF);
    writeTout(16'd5);
    ticks(4);
    chk("R6 before expiry", {26'h0, statusOut[8:3]}, 32'h0);
    ticks(1);
    chk("R6 expiry on 5th tick", {26'h0, statusOut[8:3]}, 32'h3F);
    clearAll(32'hFFFF_FFFF);
    ticks(3);
    chk("R6 hold at zero", statusOut, 32'h0);

    // R5 per-lane reload on crossing
    writeTout(16'd3);
    ticks(2);
    sendSample(3, -24'sd50, 1'b0, '0);
    ticks(1);
    chk("R5 reloaded lane survives", {26'h0, statusOut[8:3]}, 32'h37);
    chk("R2 current A crossing", {31'h0, statusOut[12]}, 32'h1);
    ticks(2);
    chk("R5 reloaded lane expires", {26'h0, statusOut[8:3]}, 32'h3F);

    // R8 mask and interrupt
    chk("R8 irq unmasked", {31'h0, irqN}, 32'h1);
    @(negedge clk); maskWrEn = 1'b1; maskWrData = 32'h40;
    @(negedge clk); maskWrEn = 1'b0;
    chk("R8 mask readback", maskOut, 32'h40);
    chk("R8 irq asserted", {31'h0, irqN}, 32'h0);
    clearAll(32'h40);
    chk("R8 irq released", {31'h0, irqN}, 32'h1);
    chk("R7 other bits sticky", {31'h0, statusOut[7]}, 32'h1);
    chk("R7 cleared bit", {31'h0, statusOut[6]}, 32'h0);

    // R7 set wins over clear
    sendSample(5, 24'sd1, 1'b0, '0);
    chk("R7 current C set", {31'h0, statusOut[14]}, 32'h1);
    sendSample(5, -24'sd1, 1'b1, 32'h4000);
    chk("R7 set beats clear", {31'h0, statusOut[14]}, 32'h1);

    // R9 reserved bits
    chk("R9 reserved bits", statusOut & ~32'h0000_7FF8, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule